// File: doc/BRIEF.md
# Energy Pulse Output Formatter

This block converts a stream of signed energy-quantum events into active-low pulses on two pins. Three configuration bits pick the output format. In the alternating format, successive events go to the two pins in turn and the sign is ignored. In the counter format, the sign of each event selects the pin, so a mechanical or discrete counter can be driven forward or backward. Every other combination of the bits, including the stepper-drive combination, leaves both pins high.

Pulse length is a whole number of sample-tick periods, taken from a pulse-width input. Since a pulse cannot overlap the next one, the output rate is limited to one pulse per (width × sample period) plus one tick of spacing. Events that arrive while a pulse is running wait in a pending store of up to 15 entries that keeps each event's sign. Events enter through a valid/ready port. An event is taken on a rising clock edge where `evt_valid_i` and `evt_ready_o` are both high. `evt_ready_o` drops only while the pending store is full. A source that sees ready low must hold the event, with its sign unchanged, until ready rises again.

Top module: `epulse_fmt`

## Requirements
- R1: After reset, both pins are high and `evt_ready_o` is high.
- R2: With mode bits {cnt,step,alt} = 3'b101 (alternating), accepted events pulse E1, E2, E1, ... in turn, starting with E1, whatever the value of `evt_neg_i`.
- R3: With mode bits 3'b100 (counter), an event with `evt_neg_i`=0 pulses E1 and an event with `evt_neg_i`=1 pulses E2.
- R4: An event accepted while the block is idle drives its pin low from the clock cycle after acceptance. The pin stays low until the edge of the PW-th sample tick after that, and goes high in the cycle after that edge.
- R5: A pulse-width input of 0 gives pulses of one sample tick.
- R6: The two pins are never low in the same cycle.
- R7: An event accepted while a pulse is running or waiting is queued. The next queued pulse starts on the first sample tick after the current pulse ends. Queued pulses keep arrival order and each keeps its own sign.
- R8: `evt_ready_o` is low while 15 events are pending. No event is lost or duplicated under back-pressure.
- R9: Any mode other than 3'b101 or 3'b100 (for example, stepper 3'b010) keeps both pins high. Events in such a mode are accepted and discarded.
- R10: In the cycle where the mode bits differ from their previous value, any event offered is discarded. From the next cycle, both pins are high, the pending store is empty, and the alternation restarts at E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick_i | input | 1 | One-cycle sample-rate tick |
| evt_valid_i | input | 1 | Energy event offered |
| evt_ready_o | output | 1 | Event can be taken |
| evt_neg_i | input | 1 | Event sign, 1 = negative energy |
| pw_i | input | PW_W | Pulse width in sample ticks (0 acts as 1) |
| cfg_cnt_en_i | input | 1 | Mode bit: counter family |
| cfg_step_en_i | input | 1 | Mode bit: stepper drive |
| cfg_alt_en_i | input | 1 | Mode bit: alternate pins |
| e1_n_o | output | 1 | Active-low pulse pin 1 |
| e2_n_o | output | 1 | Active-low pulse pin 2 |

## Verification
A pin falls one clock after the accepting edge. The bench drives each event one time unit after a rising edge and samples on the next falling edge, which is the first point where the low pin is visible. While a pin is low, the bench counts tick values at each falling edge, so it counts exactly the ticks the design samples; the count must equal the effective width. Between a pulse and the next queued pulse, the tick count seen with both pins high must be one. After a mode change, the pins, readiness and alternation restart are checked at the first falling edge after the clearing edge.

// File: rtl/epf_pkg.sv
`timescale 1ns/1ps
package epf_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ALT  = 2'd1,
    MODE_CNT  = 2'd2
  } epf_mode_e;
endpackage

// File: rtl/epf_mode_dec.sv
`timescale 1ns/1ps
module epf_mode_dec
  import epf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnt_en_i,
  input  logic      step_en_i,
  input  logic      alt_en_i,
  output epf_mode_e mode_o,
  output logic      chg_o
);
  logic [2:0] bits;
  logic [2:0] prev_q;

  assign bits = {cnt_en_i, step_en_i, alt_en_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b000;
    else        prev_q <= bits;
  end

  // Any change of the bits is a clearing event for the datapath.
  assign chg_o = (bits != prev_q);

  always_comb begin
    unique case (bits)
      3'b101:  mode_o = MODE_ALT;
      3'b100:  mode_o = MODE_CNT;
      default: mode_o = MODE_OFF; // stepper 3'b010 and all others
    endcase
  end
endmodule

// File: rtl/epf_sign_fifo.sv
`timescale 1ns/1ps
module epf_sign_fifo #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              push_sign_i,
  input  logic              pop_i,
  output logic              pop_sign_o,
  output logic [PEND_W-1:0] count_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int DEPTH = 2 ** PEND_W;

  logic [DEPTH-1:0]  mem_q;
  logic [PEND_W-1:0] wr_q, rd_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_sign_i;
        wr_q        <= wr_q + 1'b1;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      cnt_q <= cnt_q + PEND_W'(push_i) - PEND_W'(pop_i);
    end
  end

  assign pop_sign_o = mem_q[rd_q];
  assign count_o    = cnt_q;
  assign full_o     = (cnt_q == {PEND_W{1'b1}});
  assign empty_o    = (cnt_q == '0);

  // R8: the pending count never wraps past its saturation value
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i || pop_i || clr_i);

  // R7: a queued pulse is only launched when one is pending
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/epf_pulse_timer.sv
`timescale 1ns/1ps
module epf_pulse_timer #(
  parameter int PW_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            active_o,
  output logic            done_o
);
  logic            active_q;
  logic [PW_W-1:0] cnt_q;
  logic [PW_W-1:0] pw_eff;
  logic [PW_W:0]   cnt_nx;

  assign pw_eff = (pw_i == '0) ? PW_W'(1) : pw_i;
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign done_o = active_q && tick_i && (cnt_nx >= {1'b0, pw_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      if (done_o) active_q <= 1'b0;
      else        cnt_q    <= cnt_nx[PW_W-1:0];
    end
  end

  assign active_o = active_q;

  // R4: a pulse only ends on a sample tick
  a_r4_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick_i && !clr_i) |=> active_q);

  // R5: every start yields at least one active cycle, whatever the width
  a_r5_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clr_i) |=> active_q);
endmodule

// File: rtl/epulse_fmt.sv
`timescale 1ns/1ps
module epulse_fmt
  import epf_pkg::*;
#(
  parameter int PW_W   = 10,
  parameter int PEND_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_tick_i,
  input  logic            evt_valid_i,
  output logic            evt_ready_o,
  input  logic            evt_neg_i,
  input  logic [PW_W-1:0] pw_i,
  input  logic            cfg_cnt_en_i,
  input  logic            cfg_step_en_i,
  input  logic            cfg_alt_en_i,
  output logic            e1_n_o,
  output logic            e2_n_o
);
  localparam int NPINS = 2;

  epf_mode_e         mode;
  logic              clr;
  logic              mode_on;
  logic              accept, use_evt, busy;
  logic              direct_start, pend_start, start, start_sign;
  logic              push, pop, pop_sign;
  logic [PEND_W-1:0] pend_cnt;
  logic              full, empty;
  logic              active, done;
  logic              waiting_q, toggle_q, sel_q;
  logic [NPINS-1:0]  pin_n;

  epf_mode_dec u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en_i  (cfg_cnt_en_i),
    .step_en_i (cfg_step_en_i),
    .alt_en_i  (cfg_alt_en_i),
    .mode_o    (mode),
    .chg_o     (clr)
  );

  assign mode_on     = (mode != MODE_OFF);
  assign evt_ready_o = !full || !mode_on || clr;
  assign accept      = evt_valid_i && evt_ready_o;
  assign use_evt     = accept && mode_on && !clr;
  assign busy        = active || waiting_q;

  assign direct_start = use_evt && !busy;
  assign push         = use_evt && busy;
  assign pend_start   = waiting_q && smp_tick_i && !clr;
  assign pop          = pend_start;
  assign start        = direct_start || pend_start;
  assign start_sign   = direct_start ? evt_neg_i : pop_sign;

  epf_sign_fifo #(.PEND_W(PEND_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .push_i      (push),
    .push_sign_i (evt_neg_i),
    .pop_i       (pop),
    .pop_sign_o  (pop_sign),
    .count_o     (pend_cnt),
    .full_o      (full),
    .empty_o     (empty)
  );

  epf_pulse_timer #(.PW_W(PW_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .start_i  (start),
    .tick_i   (smp_tick_i),
    .pw_i     (pw_i),
    .active_o (active),
    .done_o   (done)
  );

  // Spacing state, alternation toggle and pin selection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      toggle_q  <= 1'b0;
      sel_q     <= 1'b0;
    end else if (clr) begin
      waiting_q <= 1'b0;
      toggle_q  <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      if (pend_start)                  waiting_q <= 1'b0;
      else if (done && (!empty || push)) waiting_q <= 1'b1;
      if (start) begin
        if (mode == MODE_ALT) begin
          sel_q    <= toggle_q;
          toggle_q <= ~toggle_q;
        end else begin
          sel_q <= start_sign;
        end
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign pin_n[g] = !(active && (sel_q == g[0]));
  end

  assign e1_n_o = pin_n[0];
  assign e2_n_o = pin_n[1];

  // R9: an unsupported mode keeps both pins inactive
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF && !clr) |-> (e1_n_o && e2_n_o));

  // R10: a mode change leaves pins high and nothing pending
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (e1_n_o && e2_n_o && pend_cnt == '0));

  // R7: while waiting for the spacing tick both pins are high
  a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_q |-> (e1_n_o && e2_n_o));

  // R6: never two pins low together
  a_r6_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_n_o || e2_n_o));
endmodule

// File: tb/epulse_fmt_tb.sv
`timescale 1ns/1ps
module epulse_fmt_tb;
  localparam int PW_W = 10;
  localparam int NV   = 10;
  // {mode bits cnt/step/alt, sign, pw, expected pin: 0=E1 1=E2 2=none}
  localparam logic [15:0] VEC [NV] = '{
    {3'b101, 1'b0, 10'd3, 2'd0},  // R2 first alt pulse on E1
    {3'b101, 1'b1, 10'd1, 2'd1},  // R2 then E2, sign ignored
    {3'b101, 1'b1, 10'd2, 2'd0},  // R2 back to E1
    {3'b100, 1'b1, 10'd2, 2'd1},  // R3 negative -> E2
    {3'b100, 1'b0, 10'd4, 2'd0},  // R3 positive -> E1
    {3'b100, 1'b1, 10'd0, 2'd1},  // R5 width 0 acts as 1
    {3'b101, 1'b1, 10'd2, 2'd0},  // R10 alternation restarts at E1
    {3'b010, 1'b0, 10'd2, 2'd2},  // R9 stepper: none
    {3'b000, 1'b1, 10'd2, 2'd2},  // R9 none
    {3'b111, 1'b0, 10'd2, 2'd2}   // R9 none
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic valid = 1'b0;
  logic neg = 1'b0;
  logic [PW_W-1:0] pw = '0;
  logic m_cnt = 1'b0, m_step = 1'b0, m_alt = 1'b0;
  logic ready, e1_n, e2_n;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  epulse_fmt #(.PW_W(PW_W), .PEND_W(4)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_tick_i    (tick),
    .evt_valid_i   (valid),
    .evt_ready_o   (ready),
    .evt_neg_i     (neg),
    .pw_i          (pw),
    .cfg_cnt_en_i  (m_cnt),
    .cfg_step_en_i (m_step),
    .cfg_alt_en_i  (m_alt),
    .e1_n_o        (e1_n),
    .e2_n_o        (e2_n)
  );

  initial begin : tick_gen
    int t;
    t = 0;
    forever begin
      @(posedge clk);
      #1;
      t = t + 1;
      tick = (t % 4 == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(posedge clk);
    #1;
    {m_cnt, m_step, m_alt} = m;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic send_evt(input logic s);
    @(posedge clk);
    #1;
    valid = 1'b1;
    neg = s;
    @(posedge clk);
    #1;
    valid = 1'b0;
  endtask

  // Counts ticks with both pins high (gap), then which pin is low and ticks while low.
  task automatic meas(output int pin, output int width, output int gap);
    int guard;
    gap = 0; width = 0; pin = 2; guard = 0;
    @(negedge clk);
    while (e1_n && e2_n && guard < 3000) begin
      if (tick) gap++;
      guard++;
      @(negedge clk);
    end
    pin = !e1_n ? 0 : (!e2_n ? 1 : 2);
    while ((!e1_n || !e2_n) && guard < 3000) begin
      if (tick) width++;
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int pin, width, gap, acc, quiet, expw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(e1_n && e2_n, "R1 pins high", {e1_n, e2_n}, 3);
    chk(ready, "R1 ready high", ready, 1);
    #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pw = VEC[i][11:2];
      set_mode(VEC[i][15:13]);
      send_evt(VEC[i][12]);
      if (VEC[i][1:0] == 2'd2) begin
        quiet = 1;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          if (!e1_n || !e2_n || !ready) quiet = 0;
        end
        chk(quiet == 1, "R9 pins stay high", quiet, 1);
      end else begin
        meas(pin, width, gap);
        expw = (VEC[i][11:2] == 0) ? 1 : int'(VEC[i][11:2]);
        chk(pin == int'(VEC[i][1:0]), "R2/R3 pin choice", pin, VEC[i][1:0]);
        chk(gap == 0, "R4 low next cycle", gap, 0);
        chk(width == expw, "R4/R5 width in ticks", width, expw);
      end
    end

    // R7: queued events keep order, sign and one-tick spacing
    pw = 10'd2;
    set_mode(3'b100);
    @(posedge clk); #1 valid = 1'b1; neg = 1'b0;
    @(posedge clk); #1 neg = 1'b1;
    @(posedge clk); #1 neg = 1'b0;
    @(posedge clk); #1 valid = 1'b0;
    meas(pin, width, gap);
    chk(pin == 0, "R7 first pulse E1", pin, 0);
    meas(pin, width, gap);
    chk(pin == 1, "R7 second pulse E2", pin, 1);
    chk(gap == 1, "R7 spacing one tick", gap, 1);
    chk(width == 2, "R7 second width", width, 2);
    meas(pin, width, gap);
    chk(pin == 0, "R7 third pulse E1", pin, 0);
    chk(gap == 1, "R7 spacing one tick", gap, 1);

    // R8: back-pressure after 1 running + 15 pending
    pw = 10'd50;
    set_mode(3'b100);
    acc = 0;
    @(posedge clk); #1 valid = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (ready) acc++;
      neg = k[0];
      @(posedge clk); #1;
    end
    @(negedge clk);
    chk(acc == 16, "R8 accepted count", acc, 16);
    chk(!ready, "R8 ready low when full", ready, 0);
    @(posedge clk); #1 valid = 1'b0;

    // R10: mode change clears pulse and pending store
    m_alt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(e1_n && e2_n, "R10 pins high after change", {e1_n, e2_n}, 3);
    chk(ready, "R10 ready after change", ready, 1);
    quiet = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (!e1_n || !e2_n) quiet = 0;
    end
    chk(quiet == 1, "R10 pending dropped", quiet, 1);
    pw = 10'd1;
    send_evt(1'b1);
    meas(pin, width, gap);
    chk(pin == 0, "R10 alternation restarts", pin, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule